// File: doc/BRIEF.md
# Mixed-Decay Fixed Off-Time Winding Chopper

This block regulates the current in one winding of a stepper full bridge. While it drives, it turns on one diagonal of the bridge: the high switch of one leg and the low switch of the other, chosen by the direction input. When the sensed current reaches the reference, an external comparator raises a trip flag. The block then runs an off period of fixed length. Its gate outputs are meant for the bridge gate drivers, and its flags come from the sense comparator and a zero-current detector.

The off period has three parts. The first is fast decay, where the opposite diagonal is turned on synchronously. The second is a short gap with every switch off. The third is slow decay, where both low switches are on. Once the off period ends, the block drives again. For a short window after each new drive phase begins, the trip flag is ignored so that switching transients cannot end the phase early. If zero current is detected during the off period, synchronous rectification stops and all gates stay off until the next drive phase, so the current never reverses. A change of direction always passes through a dead-time gap before the new diagonal is turned on. When the enable input drops, every gate goes low in the same cycle.

All timings are clock-cycle counts set by parameters: the total off time, the fast-decay part, the dead time and the blanking window.

Top module: `winding_chopper`

## Requirements
- R1: When `drive_en` is low, all four gate outputs are low in that same cycle, and the block returns to idle at the next clock edge. After `drive_en` rises, the first cycle is idle and drive starts on the following cycle.
- R2: In the drive phase with latched direction 1, `gate_hi_a` and `gate_lo_b` are high. With latched direction 0, `gate_hi_b` and `gate_lo_a` are high. The other two gates are low. Gate bit order used throughout is {hi_a, lo_a, hi_b, lo_b}: drive with direction 1 is 1001, and drive with direction 0 is 0110.
- R3: A trip that is accepted in the drive phase starts fast decay on the next cycle. Fast decay lasts `FAST_CYC` cycles and turns on the opposite diagonal: 0110 for direction 1 and 1001 for direction 0.
- R4: Fast decay is followed by `DT_CYC` cycles with all gates low.
- R5: The gap is followed by slow decay with both low switches on (0101) for `OFF_CYC - FAST_CYC - DT_CYC` cycles. The drive phase then resumes, so the off period from the first fast-decay cycle to the return of the drive pattern is exactly `OFF_CYC` cycles.
- R6: During the first `BLANK_CYC` cycles of every drive phase, the trip flag is ignored and the drive pattern holds. From drive cycle `BLANK_CYC` onward, a trip is accepted.
- R7: If `zero_cur` is sampled high during fast decay, the gap or slow decay, all gates are low from the next cycle until the off period ends. The timing of the off period does not change.
- R8: If `dir_fwd` differs from the latched direction during drive, fast decay, the gap or slow decay, all gates go low for `DT_CYC` cycles. Drive then starts in the direction sampled on the last dead-time cycle.
- R9: The high and low switches of the same leg are never on together.
- R10: While `rst_n` is low, the block is idle and all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drive_en | input | 1 | Enables the chopper; low forces all gates off |
| dir_fwd | input | 1 | Winding direction (1 = leg A high, leg B low) |
| trip_hit | input | 1 | Sensed current is at or above the reference |
| zero_cur | input | 1 | Winding current is near zero |
| gate_hi_a | output | 1 | High-side switch of leg A |
| gate_lo_a | output | 1 | Low-side switch of leg A |
| gate_hi_b | output | 1 | High-side switch of leg B |
| gate_lo_b | output | 1 | Low-side switch of leg B |

## Verification
State changes take effect at the clock edge that samples the input. A trip, zero flag or direction change sampled at one edge therefore shows on the gates in the following cycle. Dropping `drive_en` instead clears the gates in the same cycle, without waiting for an edge. The bench drives inputs on the falling edge and compares the gates a short time later against a behavioural model, once every cycle. The model advances on the same rising edge as the design, so every delay above is checked exactly, including the full `OFF_CYC` span measured end to end.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRIVE = 3'd1,
        ST_FAST  = 3'd2,
        ST_GAP   = 3'd3,
        ST_SLOW  = 3'd4,
        ST_REVDT = 3'd5
    } chop_state_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gate_t;

    typedef struct packed {
        chop_state_e state;
        logic        dir;
        logic        zero_seen;
    } chop_regs_t;

endpackage

// File: rtl/chop_downcnt.sv
module chop_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
(
    input  logic        en,
    input  chop_state_e state,
    input  logic        dir,
    input  logic        zero_seen,
    output gate_t       gates
);
    gate_t main_diag, back_diag;

    always_comb begin
        main_diag = dir ? '{hi_a: 1'b1, lo_a: 1'b0, hi_b: 1'b0, lo_b: 1'b1}
                        : '{hi_a: 1'b0, lo_a: 1'b1, hi_b: 1'b1, lo_b: 1'b0};
        back_diag = dir ? '{hi_a: 1'b0, lo_a: 1'b1, hi_b: 1'b1, lo_b: 1'b0}
                        : '{hi_a: 1'b1, lo_a: 1'b0, hi_b: 1'b0, lo_b: 1'b1};
        gates = '0;
        if (en) begin
            unique case (state)
                ST_DRIVE: gates = main_diag;
                ST_FAST:  gates = zero_seen ? '0 : back_diag;
                ST_SLOW:  gates = zero_seen ? '0
                                : '{hi_a: 1'b0, lo_a: 1'b1, hi_b: 1'b0, lo_b: 1'b1};
                default:  gates = '0;
            endcase
        end
    end
endmodule

// File: rtl/winding_chopper.sv
module winding_chopper
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 300,
    parameter int FAST_CYC  = 90,
    parameter int DT_CYC    = 6,
    parameter int BLANK_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic dir_fwd,
    input  logic trip_hit,
    input  logic zero_cur,
    output logic gate_hi_a,
    output logic gate_lo_a,
    output logic gate_hi_b,
    output logic gate_lo_b
);
    localparam int SLOW_CYC = OFF_CYC - FAST_CYC - DT_CYC;
    localparam int CW       = $clog2(OFF_CYC + 1);
    localparam int BW       = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] FAST_LD = CW'(FAST_CYC);
    localparam logic [CW-1:0] DT_LD   = CW'(DT_CYC);
    localparam logic [CW-1:0] SLOW_LD = CW'(SLOW_CYC);
    localparam logic [BW-1:0] BLK_LD  = BW'(BLANK_CYC);

    chop_regs_t    r_d, r_q;
    logic          ph_load, bl_load, dir_flip, ph_last;
    logic [CW-1:0] ph_val, ph_cnt;
    logic [BW-1:0] blank_cnt;
    gate_t         gates;

    chop_state_e   state_q;
    logic          dir_q, zero_seen_q;

    assign state_q     = r_q.state;
    assign dir_q       = r_q.dir;
    assign zero_seen_q = r_q.zero_seen;

    chop_downcnt #(.W(CW)) phase_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .cnt      (ph_cnt)
    );

    chop_downcnt #(.W(BW)) blank_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bl_load),
        .load_val (BLK_LD),
        .cnt      (blank_cnt)
    );

    always_comb begin
        r_d      = r_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        bl_load  = 1'b0;
        dir_flip = (dir_fwd != r_q.dir);
        ph_last  = (ph_cnt == CW'(1));
        if (!drive_en) begin
            r_d.state     = ST_IDLE;
            r_d.zero_seen = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    r_d.state = ST_DRIVE;
                    r_d.dir   = dir_fwd;
                    bl_load   = 1'b1;
                end
                ST_DRIVE: begin
                    if (dir_flip) begin
                        r_d.state = ST_REVDT;
                        ph_load   = 1'b1;
                        ph_val    = DT_LD;
                    end else if (trip_hit && blank_cnt == '0) begin
                        r_d.state = ST_FAST;
                        ph_load   = 1'b1;
                        ph_val    = FAST_LD;
                    end
                end
                ST_FAST, ST_GAP, ST_SLOW: begin
                    r_d.zero_seen = r_q.zero_seen | zero_cur;
                    if (dir_flip) begin
                        r_d.state     = ST_REVDT;
                        r_d.zero_seen = 1'b0;
                        ph_load       = 1'b1;
                        ph_val        = DT_LD;
                    end else if (ph_last) begin
                        if (r_q.state == ST_FAST) begin
                            r_d.state = ST_GAP;
                            ph_load   = 1'b1;
                            ph_val    = DT_LD;
                        end else if (r_q.state == ST_GAP) begin
                            r_d.state = ST_SLOW;
                            ph_load   = 1'b1;
                            ph_val    = SLOW_LD;
                        end else begin
                            r_d.state     = ST_DRIVE;
                            r_d.zero_seen = 1'b0;
                            bl_load       = 1'b1;
                        end
                    end
                end
                ST_REVDT: begin
                    if (ph_last) begin
                        r_d.state = ST_DRIVE;
                        r_d.dir   = dir_fwd;
                        bl_load   = 1'b1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, dir: 1'b0, zero_seen: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    chop_gate_map gate_map_i (
        .en        (drive_en),
        .state     (r_q.state),
        .dir       (r_q.dir),
        .zero_seen (r_q.zero_seen),
        .gates     (gates)
    );

    assign gate_hi_a = gates.hi_a;
    assign gate_lo_a = gates.lo_a;
    assign gate_hi_b = gates.hi_b;
    assign gate_lo_b = gates.lo_b;
endmodule

// File: rtl/chop_checker.sv
module chop_checker
    import chop_pkg::*;
#(
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input chop_state_e   state,
    input logic          dir,
    input logic          zero_seen,
    input logic [BW-1:0] blank_cnt,
    input logic          hi_a,
    input logic          lo_a,
    input logic          hi_b,
    input logic          lo_b
);
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(hi_a || lo_a || hi_b || lo_b)); // R1
    AST_DRIVE_DIAGONAL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_DRIVE) |->
            (dir ? (hi_a && lo_b && !lo_a && !hi_b) : (hi_b && lo_a && !hi_a && !lo_b))); // R2
    AST_FAST_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_FAST && !zero_seen) |->
            (dir ? (hi_b && lo_a && !hi_a && !lo_b) : (hi_a && lo_b && !lo_a && !hi_b))); // R3
    AST_GAP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> !(hi_a || lo_a || hi_b || lo_b)); // R4
    AST_SLOW_LOWSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_SLOW && !zero_seen) |-> (lo_a && lo_b && !hi_a && !hi_b)); // R5
    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_DRIVE && blank_cnt != '0) |=> (state != ST_FAST)); // R6
    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        zero_seen |-> !(hi_a || lo_a || hi_b || lo_b)); // R7
    AST_REV_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REVDT) |-> !(hi_a || lo_a || hi_b || lo_b)); // R8
    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_a && lo_a)); // R9
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_b && lo_b)); // R9
endmodule

bind winding_chopper chop_checker #(.BW(BW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (drive_en),
    .state     (state_q),
    .dir       (dir_q),
    .zero_seen (zero_seen_q),
    .blank_cnt (blank_cnt),
    .hi_a      (gate_hi_a),
    .lo_a      (gate_lo_a),
    .hi_b      (gate_hi_b),
    .lo_b      (gate_lo_b)
);

// File: tb/winding_chopper_tb_top.sv
module winding_chopper_tb_top;
    localparam int OFF   = 40;
    localparam int FAST  = 12;
    localparam int DT    = 3;
    localparam int BLANK = 4;
    localparam int SLOW  = OFF - FAST - DT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, dir = 1'b1, trip = 1'b0, zero = 1'b0;
    logic hi_a, lo_a, hi_b, lo_b;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model: 0 idle, 1 drive, 2 fast, 3 gap, 4 slow, 5 reverse dead time
    int m_phase = 0;
    int m_left = 0;
    int m_blank = 0;
    bit m_dir = 0;
    bit m_zero = 0;

    always #5 clk = ~clk;

    winding_chopper #(.OFF_CYC(OFF), .FAST_CYC(FAST), .DT_CYC(DT), .BLANK_CYC(BLANK)) dut_i (
        .clk(clk), .rst_n(rst_n), .drive_en(en), .dir_fwd(dir), .trip_hit(trip),
        .zero_cur(zero), .gate_hi_a(hi_a), .gate_lo_a(lo_a), .gate_hi_b(hi_b), .gate_lo_b(lo_b)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_blank = 0; m_dir = 0; m_zero = 0;
        end else if (!en) begin
            m_phase = 0; m_zero = 0;
        end else if (m_phase == 0) begin
            m_phase = 1; m_dir = dir; m_blank = BLANK;
        end else if (m_phase == 1) begin
            if (dir != m_dir) begin
                m_phase = 5; m_left = DT;
            end else if (m_blank == 0 && trip) begin
                m_phase = 2; m_left = FAST;
            end else if (m_blank > 0) begin
                m_blank--;
            end
        end else if (m_phase == 5) begin
            if (m_left == 1) begin
                m_phase = 1; m_dir = dir; m_blank = BLANK;
            end else m_left--;
        end else begin
            if (zero) m_zero = 1;
            if (dir != m_dir) begin
                m_phase = 5; m_left = DT; m_zero = 0;
            end else if (m_left > 1) begin
                m_left--;
            end else if (m_phase == 2) begin
                m_phase = 3; m_left = DT;
            end else if (m_phase == 3) begin
                m_phase = 4; m_left = SLOW;
            end else begin
                m_phase = 1; m_blank = BLANK; m_zero = 0;
            end
        end
    end

    function automatic logic [3:0] model_gates();
        if (!en || !rst_n) return 4'b0000;
        case (m_phase)
            1: return m_dir ? 4'b1001 : 4'b0110;
            2: return m_zero ? 4'b0000 : (m_dir ? 4'b0110 : 4'b1001);
            4: return m_zero ? 4'b0000 : 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string req_tag();
        if (!rst_n) return "R10";
        if (!en) return "R1";
        if (m_zero) return "R7";
        case (m_phase)
            1: return (m_blank > 0 && trip) ? "R6" : "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #2;
        if (!done) begin
            check({hi_a, lo_a, hi_b, lo_b} == model_gates(), req_tag(),
                  {hi_a, lo_a, hi_b, lo_b}, model_gates());
            check(!(hi_a && lo_a) && !(hi_b && lo_b), "R9", {hi_a, lo_a, hi_b, lo_b}, 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pat(input logic [3:0] p);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); #3;
            if ({hi_a, lo_a, hi_b, lo_b} == p) break;
        end
        @(negedge clk);
    endtask

    // R5: length of the whole off period from first fast cycle to drive pattern again
    task automatic measure_off(input logic [3:0] fast_p, input logic [3:0] drv_p);
        int n;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); #3;
            if ({hi_a, lo_a, hi_b, lo_b} == fast_p) break;
        end
        n = 1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); #3;
            if ({hi_a, lo_a, hi_b, lo_b} == drv_p) break;
            n++;
        end
        check(n == OFF, "R5", n, OFF);
    endtask

    initial begin
        step(3);
        #3;
        check({hi_a, lo_a, hi_b, lo_b} == 4'b0000, "R10", {hi_a, lo_a, hi_b, lo_b}, 0);
        @(negedge clk); rst_n = 1'b1;
        en = 1'b1; dir = 1'b1;
        step(8);
        trip = 1'b1;                       // held high: blanking R6 then repeated off periods
        measure_off(4'b0110, 4'b1001);
        step(50);
        wait_pat(4'b0110);                 // zero during fast decay, R7
        step(3); zero = 1'b1; step(1); zero = 1'b0;
        step(40);
        wait_pat(4'b0101);                 // zero during slow decay, R7
        step(2); zero = 1'b1; step(1); zero = 1'b0;
        step(30);
        trip = 1'b0; step(20);
        dir = 1'b0; step(15);              // R8 in drive
        trip = 1'b1;
        wait_pat(4'b1001);                 // R8 in fast decay
        dir = 1'b1; step(10);
        wait_pat(4'b0110);
        step(FAST - 1);                    // R8 in the gap
        dir = 1'b0; step(10);
        wait_pat(4'b0101);                 // R8 in slow decay
        dir = 1'b1; step(10);
        wait_pat(4'b0110);                 // R1 mid fast decay
        en = 1'b0; step(3);
        en = 1'b1; step(30);
        dir = 1'b0;
        measure_off(4'b1001, 4'b0110);     // R5 with direction 0
        step(20);
        rst_n = 1'b0; step(2);             // R10 mid run
        rst_n = 1'b1; step(20);
        trip = 1'b0; en = 1'b0; step(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule